// File: doc/BRIEF.md
# Dual-Slot Management Command Responder

This block answers management commands aimed at a set of numbered buffer pools. A requester places a command on a command port. The command carries an 8-bit verb and a pool number. The top bit of the verb is a phase flag. The responder starts work only when that flag differs from the phase of the last command it handled, so a requester can rewrite the command register freely and trigger execution by flipping the flag.

Two commands are supported. An acquire removes up to eight buffer descriptors from one pool. A query reports which pools hold at least one descriptor. Each result is written into one of two response slots, and the command's phase flag selects the slot. Completion is signalled only by a nonzero verb appearing in that slot, so the requester polls a single byte. The slot that has not completed always reads a zero verb.

Descriptors come into the pools through a release stream with valid/ready handshake. A simple last-in-first-out store per pool stands in for real pool storage.

Top module: `mcr_responder`

## Requirements
- R1: After reset both response verbs read zero, `cmd_ready_o` and `rel_ready_o` are high, and the remembered phase is 0, so the first command to execute must carry phase 1.
- R2: A command accepted with a phase bit (verb bit 7) equal to the remembered phase is ignored. Neither slot changes, no pool changes, and `cmd_ready_o` stays high.
- R3: A new command uses response slot 0 when its phase is 0 and slot 1 when its phase is 1. From the cycle after acceptance until completion, that slot's verb reads zero.
- R4: On completion the used slot's verb is set and the other slot's verb is cleared to zero. At no time do both slots show a nonzero verb.
- R5: Verb bits 6:4 select the command: 001 is acquire, 100 is query. For acquire, bits 3:0 request 1 to 8 buffers. The acquire returns min(request, pool fill) descriptors, newest first, in words 0 upward. Unused words read zero. The response verb is phase, 001, and the count supplied.
- R6: An acquire on an empty pool completes with a count of 0 and leaves all data words at zero.
- R7: A query completes with verb phase, 100, 0000. Data word 0 carries a mask in which bit p is set when pool p holds at least one descriptor.
- R8: Any other command code, or an acquire requesting 0 or more than 8 buffers, completes with verb phase, 110, 0000 and changes no pool.
- R9: If `store_fault_i` is high in a cycle while an acquire is draining its pool, draining stops and the response verb is phase, 111, 0000. Descriptors not yet removed stay in the pool.
- R10: `rel_ready_o` is low when the addressed pool is full (4 entries by default) or is the pool of an acquire in progress. A release to any other pool transfers in the same cycle as an acquire pop.
- R11: `cmd_ready_o` drops in the cycle after a new command is accepted and returns high only after the response has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Responder idle and taking commands |
| cmd_verb_i | input | 8 | Phase bit 7, command code 6:4, count 3:0 |
| cmd_pool_i | input | 6 | Target pool number |
| rel_valid_i | input | 1 | Release descriptor offered |
| rel_ready_o | output | 1 | Release can be stored this cycle |
| rel_pool_i | input | 6 | Pool receiving the descriptor |
| rel_data_i | input | 64 | Buffer descriptor |
| store_fault_i | input | 1 | Storage fault seen while an acquire drains |
| rd_slot_i | input | 1 | Response slot to read |
| rd_word_i | input | 3 | Data word within the slot |
| rd_verb_o | output | 8 | Verb of the selected slot |
| rd_data_o | output | 64 | Selected data word |

## Verification
The release stream and an executing acquire can act in the same clock edge. The pop belongs to the command engine and the push belongs to the release port. The bench starts an acquire for 8 buffers on a pool holding 4. While that acquire drains, it offers one release to an unrelated pool and then one to the draining pool. The first release must be taken while `cmd_ready_o` is low. The second must stall until the response is written, and a later acquire must return the stalled descriptor. A checker property separately forbids a push and a pop on the same pool in one cycle.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_ACQUIRE = 3'd1,
    CMD_QUERY   = 3'd4,
    CMD_INVALID = 3'd6,
    CMD_FAULT   = 3'd7
  } cmd_code_e;

  typedef enum logic [1:0] {
    OP_ACQUIRE,
    OP_QUERY,
    OP_REJECT
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_FINISH
  } eng_state_e;

  typedef struct packed {
    logic       phase;
    logic [2:0] code;
    logic [3:0] count;
  } verb_t;

endpackage

// File: rtl/mcr_decode.sv
module mcr_decode
  import mcr_pkg::*;
#(
  parameter int MAX_BUFS = 8
) (
  input  verb_t verb_i,
  output op_e   op_o
);

  always_comb begin
    op_o = OP_REJECT;
    if (verb_i.code == CMD_ACQUIRE) begin
      if (verb_i.count != 4'd0 && 32'(verb_i.count) <= MAX_BUFS) begin
        op_o = OP_ACQUIRE;
      end
    end else if (verb_i.code == CMD_QUERY) begin
      op_o = OP_QUERY;
    end
  end

endmodule

// File: rtl/mcr_pool_stack.sv
module mcr_pool_stack #(
  parameter int NUM_POOLS = 64,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 64,
  localparam int POOL_W   = $clog2(NUM_POOLS),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int ADDR_W   = $clog2(NUM_POOLS * DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_en_i,
  input  logic [POOL_W-1:0]    push_pool_i,
  input  logic [DATA_W-1:0]    push_data_i,
  output logic                 push_full_o,
  input  logic                 pop_en_i,
  input  logic [POOL_W-1:0]    pop_pool_i,
  output logic                 pop_avail_o,
  output logic [DATA_W-1:0]    pop_data_o,
  output logic [NUM_POOLS-1:0] nonempty_o
);

  logic [DATA_W-1:0] mem_q [NUM_POOLS*DEPTH];
  logic [CNT_W-1:0]  cnt_q [NUM_POOLS];

  function automatic logic [ADDR_W-1:0] addr_of(input logic [POOL_W-1:0] pool,
                                                input logic [CNT_W-1:0]  slot);
    return ADDR_W'(pool) * ADDR_W'(DEPTH) + ADDR_W'(slot);
  endfunction

  logic [CNT_W-1:0] push_cnt;
  logic [CNT_W-1:0] pop_cnt;

  assign push_cnt    = cnt_q[push_pool_i];
  assign pop_cnt     = cnt_q[pop_pool_i];
  assign push_full_o = (push_cnt == CNT_W'(DEPTH));
  assign pop_avail_o = (pop_cnt != '0);
  assign pop_data_o  = mem_q[addr_of(pop_pool_i, pop_cnt - 1'b1)];

  always_ff @(posedge clk_i) begin
    if (push_en_i) begin
      mem_q[addr_of(push_pool_i, push_cnt)] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_POOLS; p++) cnt_q[p] <= '0;
    end else begin
      for (int p = 0; p < NUM_POOLS; p++) begin
        if (push_en_i && push_pool_i == POOL_W'(p)) begin
          cnt_q[p] <= cnt_q[p] + 1'b1;
        end else if (pop_en_i && pop_pool_i == POOL_W'(p)) begin
          cnt_q[p] <= cnt_q[p] - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_POOLS; g++) begin : g_mask
    assign nonempty_o[g] = (cnt_q[g] != '0);
  end

endmodule

// File: rtl/mcr_slots.sv
module mcr_slots #(
  parameter int DATA_W = 64,
  parameter int WORDS  = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_en_i,
  input  logic              clr_slot_i,
  input  logic              wr_en_i,
  input  logic              wr_slot_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fin_en_i,
  input  logic              fin_slot_i,
  input  logic [7:0]        fin_verb_i,
  input  logic              rd_slot_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [7:0]        rd_verb_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0][7:0]   verbs_o
);

  logic [1:0][7:0]   verb_q;
  logic [DATA_W-1:0] data_q [2][WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      verb_q <= '0;
    end else if (fin_en_i) begin
      verb_q[fin_slot_i]  <= fin_verb_i;
      verb_q[!fin_slot_i] <= 8'h00;
    end else if (clr_en_i) begin
      verb_q[clr_slot_i] <= 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < WORDS; w++) data_q[s][w] <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        for (int w = 0; w < WORDS; w++) begin
          if (clr_en_i && clr_slot_i == s[0]) begin
            data_q[s][w] <= '0;
          end else if (wr_en_i && wr_slot_i == s[0] && wr_idx_i == IDX_W'(w)) begin
            data_q[s][w] <= wr_data_i;
          end
        end
      end
    end
  end

  assign rd_verb_o = verb_q[rd_slot_i];
  assign rd_data_o = data_q[rd_slot_i][rd_idx_i];
  assign verbs_o   = verb_q;

endmodule

// File: rtl/mcr_engine.sv
module mcr_engine
  import mcr_pkg::*;
#(
  parameter int NUM_POOLS = 64,
  parameter int MAX_BUFS  = 8,
  parameter int DATA_W    = 64,
  localparam int POOL_W   = $clog2(NUM_POOLS),
  localparam int IDX_W    = $clog2(MAX_BUFS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  verb_t                cmd_verb_i,
  input  logic [POOL_W-1:0]    cmd_pool_i,
  input  op_e                  op_i,
  output logic                 cmd_ready_o,
  output logic                 last_phase_o,
  output logic                 cur_slot_o,
  output logic                 pop_en_o,
  output logic [POOL_W-1:0]    pop_pool_o,
  input  logic                 pop_avail_i,
  input  logic [DATA_W-1:0]    pop_data_i,
  input  logic                 fault_i,
  input  logic [NUM_POOLS-1:0] mask_i,
  output logic                 lock_en_o,
  output logic                 clr_en_o,
  output logic                 clr_slot_o,
  output logic                 wr_en_o,
  output logic                 wr_slot_o,
  output logic [IDX_W-1:0]     wr_idx_o,
  output logic [DATA_W-1:0]    wr_data_o,
  output logic                 fin_en_o,
  output logic                 fin_slot_o,
  output logic [7:0]           fin_verb_o
);

  eng_state_e        state_q;
  op_e               op_q;
  logic              last_phase_q;
  logic              phase_q;
  logic [POOL_W-1:0] pool_q;
  logic [3:0]        want_q;
  logic [3:0]        got_q;
  logic              fault_q;

  logic  fire;
  logic  can_pop;
  verb_t rsp;

  assign cmd_ready_o  = (state_q == ST_IDLE);
  assign fire         = cmd_ready_o && cmd_valid_i && (cmd_verb_i.phase != last_phase_q);
  assign can_pop      = (state_q == ST_DRAIN) && !fault_i && (got_q < want_q) && pop_avail_i;
  assign last_phase_o = last_phase_q;
  assign cur_slot_o   = phase_q;

  assign pop_en_o   = can_pop;
  assign pop_pool_o = pool_q;
  assign lock_en_o  = (state_q != ST_IDLE) && (op_q == OP_ACQUIRE);

  assign clr_en_o   = fire;
  assign clr_slot_o = cmd_verb_i.phase;

  assign wr_en_o    = can_pop || (state_q == ST_FINISH && op_q == OP_QUERY);
  assign wr_slot_o  = phase_q;
  assign wr_idx_o   = (state_q == ST_FINISH) ? '0 : got_q[IDX_W-1:0];
  assign wr_data_o  = (state_q == ST_FINISH) ? DATA_W'(mask_i) : pop_data_i;

  always_comb begin
    rsp.phase = phase_q;
    rsp.count = 4'd0;
    rsp.code  = CMD_INVALID;
    case (op_q)
      OP_ACQUIRE: begin
        if (fault_q) begin
          rsp.code = CMD_FAULT;
        end else begin
          rsp.code  = CMD_ACQUIRE;
          rsp.count = got_q;
        end
      end
      OP_QUERY: rsp.code = CMD_QUERY;
      default:  rsp.code = CMD_INVALID;
    endcase
  end

  assign fin_en_o   = (state_q == ST_FINISH);
  assign fin_slot_o = phase_q;
  assign fin_verb_o = rsp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      op_q         <= OP_REJECT;
      last_phase_q <= 1'b0;
      phase_q      <= 1'b0;
      pool_q       <= '0;
      want_q       <= '0;
      got_q        <= '0;
      fault_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (fire) begin
            last_phase_q <= cmd_verb_i.phase;
            phase_q      <= cmd_verb_i.phase;
            op_q         <= op_i;
            pool_q       <= cmd_pool_i;
            want_q       <= cmd_verb_i.count;
            got_q        <= '0;
            fault_q      <= 1'b0;
            state_q      <= (op_i == OP_ACQUIRE) ? ST_DRAIN : ST_FINISH;
          end
        end
        ST_DRAIN: begin
          if (fault_i) begin
            fault_q <= 1'b1;
            state_q <= ST_FINISH;
          end else if (can_pop) begin
            got_q <= got_q + 4'd1;
          end else begin
            state_q <= ST_FINISH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mcr_responder.sv
module mcr_responder
  import mcr_pkg::*;
#(
  parameter int NUM_POOLS  = 64,
  parameter int POOL_DEPTH = 4,
  parameter int MAX_BUFS   = 8,
  parameter int DATA_W     = 64,
  localparam int POOL_W    = $clog2(NUM_POOLS),
  localparam int IDX_W     = $clog2(MAX_BUFS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [7:0]        cmd_verb_i,
  input  logic [POOL_W-1:0] cmd_pool_i,
  input  logic              rel_valid_i,
  output logic              rel_ready_o,
  input  logic [POOL_W-1:0] rel_pool_i,
  input  logic [DATA_W-1:0] rel_data_i,
  input  logic              store_fault_i,
  input  logic              rd_slot_i,
  input  logic [IDX_W-1:0]  rd_word_i,
  output logic [7:0]        rd_verb_o,
  output logic [DATA_W-1:0] rd_data_o
);

  verb_t                cmd_verb;
  op_e                  op;
  logic                 last_phase;
  logic                 cur_slot;
  logic                 pop_en;
  logic [POOL_W-1:0]    pop_pool;
  logic                 pop_avail;
  logic [DATA_W-1:0]    pop_data;
  logic                 push_full;
  logic                 push_en;
  logic [NUM_POOLS-1:0] nonempty;
  logic                 lock_en;
  logic                 clr_en, clr_slot;
  logic                 wr_en, wr_slot;
  logic [IDX_W-1:0]     wr_idx;
  logic [DATA_W-1:0]    wr_data;
  logic                 fin_en, fin_slot;
  logic [7:0]           fin_verb;
  logic [1:0][7:0]      slot_verbs;

  assign cmd_verb    = verb_t'(cmd_verb_i);
  assign rel_ready_o = !push_full && !(lock_en && rel_pool_i == pop_pool);
  assign push_en     = rel_valid_i && rel_ready_o;

  mcr_decode #(.MAX_BUFS(MAX_BUFS)) u_decode (
    .verb_i (cmd_verb),
    .op_o   (op)
  );

  mcr_pool_stack #(
    .NUM_POOLS (NUM_POOLS),
    .DEPTH     (POOL_DEPTH),
    .DATA_W    (DATA_W)
  ) u_pools (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_en_i   (push_en),
    .push_pool_i (rel_pool_i),
    .push_data_i (rel_data_i),
    .push_full_o (push_full),
    .pop_en_i    (pop_en),
    .pop_pool_i  (pop_pool),
    .pop_avail_o (pop_avail),
    .pop_data_o  (pop_data),
    .nonempty_o  (nonempty)
  );

  mcr_engine #(
    .NUM_POOLS (NUM_POOLS),
    .MAX_BUFS  (MAX_BUFS),
    .DATA_W    (DATA_W)
  ) u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_verb_i   (cmd_verb),
    .cmd_pool_i   (cmd_pool_i),
    .op_i         (op),
    .cmd_ready_o  (cmd_ready_o),
    .last_phase_o (last_phase),
    .cur_slot_o   (cur_slot),
    .pop_en_o     (pop_en),
    .pop_pool_o   (pop_pool),
    .pop_avail_i  (pop_avail),
    .pop_data_i   (pop_data),
    .fault_i      (store_fault_i),
    .mask_i       (nonempty),
    .lock_en_o    (lock_en),
    .clr_en_o     (clr_en),
    .clr_slot_o   (clr_slot),
    .wr_en_o      (wr_en),
    .wr_slot_o    (wr_slot),
    .wr_idx_o     (wr_idx),
    .wr_data_o    (wr_data),
    .fin_en_o     (fin_en),
    .fin_slot_o   (fin_slot),
    .fin_verb_o   (fin_verb)
  );

  mcr_slots #(
    .DATA_W (DATA_W),
    .WORDS  (MAX_BUFS)
  ) u_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_en_i   (clr_en),
    .clr_slot_i (clr_slot),
    .wr_en_i    (wr_en),
    .wr_slot_i  (wr_slot),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data),
    .fin_en_i   (fin_en),
    .fin_slot_i (fin_slot),
    .fin_verb_i (fin_verb),
    .rd_slot_i  (rd_slot_i),
    .rd_idx_i   (rd_word_i),
    .rd_verb_o  (rd_verb_o),
    .rd_data_o  (rd_data_o),
    .verbs_o    (slot_verbs)
  );

endmodule

// File: rtl/mcr_checker.sv
module mcr_checker #(
  parameter int POOL_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_i,
  input logic              cmd_phase_i,
  input logic              last_phase_i,
  input logic              cur_slot_i,
  input logic [1:0][7:0]   slot_verbs_i,
  input logic              pop_en_i,
  input logic [POOL_W-1:0] pop_pool_i,
  input logic              push_en_i,
  input logic [POOL_W-1:0] push_pool_i
);

  assert_stale_phase_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_i && cmd_phase_i == last_phase_i)
      |=> (cmd_ready_i && $stable(slot_verbs_i)));

  assert_pending_slot_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ready_i |-> (slot_verbs_i[cur_slot_i] == 8'h00));

  assert_single_live_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({slot_verbs_i[1] != 8'h00, slot_verbs_i[0] != 8'h00}) <= 1);

  assert_no_push_pop_clash_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_en_i && push_en_i && pop_pool_i == push_pool_i));

  assert_busy_after_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_i && cmd_phase_i != last_phase_i) |=> !cmd_ready_i);

endmodule

bind mcr_responder mcr_checker #(.POOL_W(POOL_W)) u_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_ready_i  (cmd_ready_o),
  .cmd_phase_i  (cmd_verb_i[7]),
  .last_phase_i (last_phase),
  .cur_slot_i   (cur_slot),
  .slot_verbs_i (slot_verbs),
  .pop_en_i     (pop_en),
  .pop_pool_i   (pop_pool),
  .push_en_i    (push_en),
  .push_pool_i  (rel_pool_i)
);

// File: tb/test_mcr_responder.sv
`timescale 1ns/100ps
module test_mcr_responder;

  localparam int NP = 64;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_verb = '0;
  logic [5:0]  cmd_pool = '0;
  logic        rel_valid = 1'b0;
  logic        rel_ready;
  logic [5:0]  rel_pool = '0;
  logic [63:0] rel_data = '0;
  logic        store_fault = 1'b0;
  logic        rd_slot = 1'b0;
  logic [2:0]  rd_word = '0;
  logic [7:0]  rd_verb;
  logic [63:0] rd_data;

  always #2 clk = ~clk;

  mcr_responder i_mcr_responder (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_verb_i(cmd_verb), .cmd_pool_i(cmd_pool),
    .rel_valid_i(rel_valid), .rel_ready_o(rel_ready),
    .rel_pool_i(rel_pool), .rel_data_i(rel_data),
    .store_fault_i(store_fault),
    .rd_slot_i(rd_slot), .rd_word_i(rd_word),
    .rd_verb_o(rd_verb), .rd_data_o(rd_data)
  );

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [63:0] mdl [NP][DEPTH];
  int          mcnt [NP];
  logic [63:0] exp_buf [8];
  logic        ph = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_verb(input logic p, input logic [2:0] code, input logic [3:0] n);
    return {p, code, n};
  endfunction

  function automatic logic [63:0] model_mask();
    logic [63:0] m = '0;
    for (int p = 0; p < NP; p++) m[p] = (mcnt[p] != 0);
    return m;
  endfunction

  function automatic logic [3:0] model_acquire(input int pool, input int n);
    int k = 0;
    for (int w = 0; w < 8; w++) exp_buf[w] = '0;
    while (k < n && mcnt[pool] > 0) begin
      mcnt[pool]--;
      exp_buf[k] = mdl[pool][mcnt[pool]];
      k++;
    end
    return 4'(k);
  endfunction

  task automatic release_buf(input int pool, input logic [63:0] d);
    @(negedge clk);
    rel_valid = 1'b1; rel_pool = 6'(pool); rel_data = d;
    while (!rel_ready) @(negedge clk);
    @(negedge clk);
    rel_valid = 1'b0;
    mdl[pool][mcnt[pool]] = d;
    mcnt[pool]++;
  endtask

  task automatic send_cmd(input logic [7:0] v, input int pool);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_verb = v; cmd_pool = 6'(pool);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rsp(input logic s, input logic [7:0] ev, input string req, input bit chk_data);
    int n = 0;
    rd_slot = s; rd_word = '0; #0.2;
    while (rd_verb == 8'h00 && n < 60) begin @(negedge clk); #0.2; n++; end
    chk(rd_verb == ev, req, 64'(rd_verb), 64'(ev));
    rd_slot = !s; #0.2;
    chk(rd_verb == 8'h00, "R4 other slot cleared", 64'(rd_verb), 64'h0);
    if (chk_data) begin
      for (int w = 0; w < 8; w++) begin
        rd_slot = s; rd_word = 3'(w); #0.2;
        chk(rd_data == exp_buf[w], req, rd_data, exp_buf[w]);
      end
    end
  endtask

  task automatic do_acquire(input int pool, input int n, input string req);
    logic [3:0] k;
    ph = !ph;
    k = model_acquire(pool, n);
    send_cmd(mk_verb(ph, 3'b001, 4'(n)), pool);
    rd_slot = ph; #0.2;
    chk(rd_verb == 8'h00, "R3 pending slot zero", 64'(rd_verb), 64'h0);
    wait_rsp(ph, mk_verb(ph, 3'b001, k), req, 1'b1);
  endtask

  task automatic do_query(input string req);
    ph = !ph;
    for (int w = 0; w < 8; w++) exp_buf[w] = '0;
    exp_buf[0] = model_mask();
    send_cmd(mk_verb(ph, 3'b100, 4'd0), 0);
    wait_rsp(ph, mk_verb(ph, 3'b100, 4'd0), req, 1'b1);
  endtask

  task automatic do_reject(input logic [2:0] code, input logic [3:0] n, input string req);
    ph = !ph;
    for (int w = 0; w < 8; w++) exp_buf[w] = '0;
    send_cmd(mk_verb(ph, code, n), 1);
    wait_rsp(ph, mk_verb(ph, 3'b110, 4'd0), req, 1'b1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v0, v1;
    logic [3:0] k;
    void'($urandom(32'h0005eed1));
    for (int p = 0; p < NP; p++) mcnt[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 cmd_ready", 64'(cmd_ready), 64'h1);
    chk(rel_ready == 1'b1, "R1 rel_ready", 64'(rel_ready), 64'h1);
    rd_slot = 1'b0; #0.2;
    chk(rd_verb == 8'h00, "R1 slot0 verb", 64'(rd_verb), 64'h0);
    rd_slot = 1'b1; #0.2;
    chk(rd_verb == 8'h00, "R1 slot1 verb", 64'(rd_verb), 64'h0);

    // R2 phase 0 equals reset phase: ignored
    release_buf(5, 64'hA5A5_0000_0000_0005);
    send_cmd(8'h01, 5);
    chk(cmd_ready == 1'b1, "R2 ready after stale phase", 64'(cmd_ready), 64'h1);
    repeat (3) @(negedge clk);
    rd_slot = 1'b0; #0.2;
    chk(rd_verb == 8'h00, "R2 slot0 untouched", 64'(rd_verb), 64'h0);

    // R6 empty pool, R5 normal acquire
    do_acquire(9, 3, "R6 empty pool acquire");
    do_acquire(5, 2, "R5 partial acquire");

    // R2 again: resend with same phase, slots must not change
    rd_slot = 1'b0; #0.2; v0 = rd_verb;
    rd_slot = 1'b1; #0.2; v1 = rd_verb;
    release_buf(5, 64'h1234_5678_9abc_def0);
    send_cmd(mk_verb(ph, 3'b001, 4'd1), 5);
    chk(cmd_ready == 1'b1, "R2 ready after repeat", 64'(cmd_ready), 64'h1);
    repeat (3) @(negedge clk);
    rd_slot = 1'b0; #0.2;
    chk(rd_verb == v0, "R2 slot0 stable", 64'(rd_verb), 64'(v0));
    rd_slot = 1'b1; #0.2;
    chk(rd_verb == v1, "R2 slot1 stable", 64'(rd_verb), 64'(v1));

    // R8 rejects
    do_reject(3'b010, 4'd1, "R8 unknown code");
    do_reject(3'b001, 4'd0, "R8 zero count");
    do_reject(3'b001, 4'd9, "R8 count nine");

    // R7 query
    do_query("R7 query mask");

    // R9 fault while draining
    release_buf(20, 64'hFA17_0000_0000_0001);
    release_buf(20, 64'hFA17_0000_0000_0002);
    store_fault = 1'b1;
    ph = !ph;
    for (int w = 0; w < 8; w++) exp_buf[w] = '0;
    send_cmd(mk_verb(ph, 3'b001, 4'd2), 20);
    wait_rsp(ph, mk_verb(ph, 3'b111, 4'd0), "R9 fault verb", 1'b1);
    store_fault = 1'b0;
    do_acquire(20, 8, "R9 pool kept after fault");

    // R10 full pool back-pressure
    for (int i = 0; i < DEPTH; i++) release_buf(30, 64'h3000 + 64'(i));
    @(negedge clk);
    rel_valid = 1'b1; rel_pool = 6'd30; rel_data = 64'hdead;
    #0.2;
    chk(rel_ready == 1'b0, "R10 full pool stalls", 64'(rel_ready), 64'h0);
    rel_valid = 1'b0;
    do_acquire(30, 4, "R5 full drain LIFO");

    // R10 release concurrent with draining acquire
    for (int i = 0; i < DEPTH; i++) release_buf(40, 64'h4000 + 64'(i));
    ph = !ph;
    k = model_acquire(40, 8);
    send_cmd(mk_verb(ph, 3'b001, 4'd8), 40);
    rel_valid = 1'b1; rel_pool = 6'd41; rel_data = 64'h4100; #0.2;
    chk(rel_ready == 1'b1 && cmd_ready == 1'b0, "R10 other pool taken while busy",
        64'({rel_ready, cmd_ready}), 64'h2);
    mdl[41][mcnt[41]] = 64'h4100; mcnt[41]++;
    @(negedge clk);
    rel_pool = 6'd40; rel_data = 64'h40FF; #0.2;
    chk(rel_ready == 1'b0, "R10 draining pool stalls", 64'(rel_ready), 64'h0);
    while (!rel_ready) @(negedge clk);
    @(negedge clk);
    rel_valid = 1'b0;
    wait_rsp(ph, mk_verb(ph, 3'b001, k), "R10 acquire during releases", 1'b1);
    mdl[40][mcnt[40]] = 64'h40FF; mcnt[40]++;
    do_acquire(40, 1, "R10 stalled release landed");
    do_acquire(41, 1, "R10 concurrent release landed");

    // R11 busy window
    release_buf(50, 64'h5050);
    ph = !ph;
    k = model_acquire(50, 1);
    send_cmd(mk_verb(ph, 3'b001, 4'd1), 50);
    chk(cmd_ready == 1'b0, "R11 busy after accept", 64'(cmd_ready), 64'h0);
    wait_rsp(ph, mk_verb(ph, 3'b001, k), "R11 completes", 1'b1);

    // constrained random mix on pools 0..7
    for (int it = 0; it < 200; it++) begin
      int r = int'($urandom % 5);
      int p = int'($urandom % 8);
      if (r < 2) begin
        if (mcnt[p] < DEPTH) release_buf(p, {$urandom, $urandom});
      end else if (r < 4) begin
        do_acquire(p, 1 + int'($urandom % 8), "R5 random acquire");
      end else begin
        do_query("R7 random query");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule